// File: doc/BRIEF.md
# Three-Phase Switching Period Generator

This block turns one timing source into three switching-period streams for a three-channel converter controller. Each channel gets a one-cycle period-start pulse and a duty-limit window. The three channels run at the same frequency, spaced a third of a period apart, so their switching edges do not line up and the input ripple is spread out. Every period is twelve source steps long, so each channel switches at one twelfth of the source rate.

A step comes from one of two places. The first is a qualified rising edge of an external clock pin, which is asynchronous and passes through a synchronizer. The second is a single-cycle enable pulse from an internal oscillator. An activity monitor chooses the source. It falls back to the internal source when the external pin stops toggling, and it returns to the external pin after a run of closely spaced edges. One divide counter serves all three phases. Reset clears it to zero, so the phase relationship after reset is always the same.

Top module: `tpc_three_phase_gen`

## Requirements
- R1: After synchronous reset, the internal source is selected (`src_int` = 1), the shared step counter is 0, all `period_start` bits are 0 and every `duty_win` bit is 1.
- R2: Each step advances a counter modulo 12 (DIV). Channel i's `period_start[i]` pulses for exactly one cycle, in the cycle after the step that brings the counter to i*4, so each channel pulses once every 12 steps.
- R3: Channel 1 starts 4 steps after channel 0, and channel 2 starts 4 steps after channel 1 (counts 0, 4 and 8). No two `period_start` bits are high in the same cycle.
- R4: `duty_win[i]` is low only while the counter holds the count just before channel i's own start, (i*4+11) mod 12, and is high for the other 11 counts. At most one window is low at a time.
- R5: While the external source is selected (`src_int` = 0), each rising edge of `ext_clk` is one step. The edge takes effect two `clk` edges after it is sampled, through two synchronizer flops. `int_tick` has no effect in this mode.
- R6: While the internal source is selected, each cycle with `int_tick` = 1 is one step, and `ext_clk` edges do not advance the counter.
- R7: While external is selected, if TIMEOUT cycles pass after the last detected edge with no new edge, `src_int` rises on the following cycle.
- R8: While internal is selected, the LOCK_EDGES-th consecutive detected external edge returns the selection to external, with `src_int` = 0 on the next cycle.
- R9: While internal is selected, a gap of TIMEOUT cycles without an external edge clears the consecutive-edge count.
- R10: The external clock must stay high for at least 2 `clk` cycles and low for at least 2 `clk` cycles. Each such high pulse then gives exactly one step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_clk | input | 1 | Asynchronous external timing clock |
| int_tick | input | 1 | Internal oscillator step enable, one cycle wide |
| period_start | output | PHASES | Per-channel period start pulse |
| duty_win | output | PHASES | Per-channel duty-limit window, high means switching is allowed |
| src_int | output | 1 | 1 while the internal source is selected |

## Verification
The hardest state to reach from the ports is a consecutive-edge count that was partly filled and then cleared by a gap. This is only visible indirectly: a later burst that would have been long enough together with the earlier edges must still leave the internal source selected. The stimulus sends three edges, holds the pin low past the timeout, sends three more and checks `src_int`. It then waits again and sends a full run of edges to reach the switch back. Counter motion is compared on every cycle against a behavioural model. During internal-mode bursts this shows that external edges cause no steps, and in external mode it shows that a busy `int_tick` is ignored.

// File: rtl/tpc_pkg.sv
package tpc_pkg;
  typedef enum logic {SRC_EXT = 1'b0, SRC_INT = 1'b1} src_e;

  function automatic int tap_of(input int idx, input int div, input int phases);
    return (idx * div) / phases;
  endfunction
endpackage

// File: rtl/tpc_edge_sync.sv
module tpc_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise
);
  logic [SYNC_STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[SYNC_STAGES-1:0], async_in};
  end

  assign rise = sh[SYNC_STAGES-1] & ~sh[SYNC_STAGES];

  AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise); // R10
endmodule

// File: rtl/tpc_src_select.sv
module tpc_src_select
  import tpc_pkg::*;
#(
  parameter int TIMEOUT    = 64,
  parameter int LOCK_EDGES = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic ext_edge,
  input  logic int_tick,
  output logic step,
  output logic use_int
);
  localparam int IW = $clog2(TIMEOUT + 1);
  localparam int LW = $clog2(LOCK_EDGES + 1);

  src_e            src;
  logic [IW-1:0]   idle;
  logic [LW-1:0]   lock;
  logic            stale;

  assign stale   = (idle == IW'(TIMEOUT));
  assign use_int = (src == SRC_INT);
  assign step    = use_int ? int_tick : ext_edge;

  always_ff @(posedge clk) begin
    if (rst) begin
      src  <= SRC_INT;
      idle <= '0;
      lock <= '0;
    end else begin
      if (ext_edge)    idle <= '0;
      else if (!stale) idle <= idle + 1'b1;

      if (src == SRC_EXT) begin
        if (stale) begin
          src  <= SRC_INT;
          lock <= '0;
        end
      end else if (ext_edge) begin
        if (lock == LW'(LOCK_EDGES - 1)) begin
          src  <= SRC_EXT;
          lock <= '0;
        end else begin
          lock <= lock + 1'b1;
        end
      end else if (stale) begin
        lock <= '0;
      end
    end
  end

  AST_STALE_SWITCH: assert property (@(posedge clk) disable iff (rst)
    (!use_int && stale) |=> use_int); // R7
  AST_EDGE_CLEARS_IDLE: assert property (@(posedge clk) disable iff (rst)
    ext_edge |=> (idle == '0)); // R7
  AST_GAP_CLEARS_LOCK: assert property (@(posedge clk) disable iff (rst)
    (use_int && stale && !ext_edge) |=> (lock == '0)); // R9
  AST_LOCK_BOUND: assert property (@(posedge clk) disable iff (rst)
    lock < LW'(LOCK_EDGES)); // R8
endmodule

// File: rtl/tpc_phase_div.sv
module tpc_phase_div
  import tpc_pkg::*;
#(
  parameter int DIV    = 12,
  parameter int PHASES = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  output logic [PHASES-1:0] start_o,
  output logic [PHASES-1:0] win_o
);
  localparam int CW = $clog2(DIV);

  logic [CW-1:0] cnt, cnt_nx;

  assign cnt_nx = !step ? cnt : ((cnt == CW'(DIV - 1)) ? '0 : cnt + 1'b1);

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt_nx;
  end

  for (genvar g = 0; g < PHASES; g++) begin : g_ph
    localparam int TAP  = tap_of(g, DIV, PHASES);
    localparam int LAST = (TAP + DIV - 1) % DIV;
    always_ff @(posedge clk) begin
      if (rst) begin
        start_o[g] <= 1'b0;
        win_o[g]   <= (LAST != 0);
      end else begin
        start_o[g] <= step && (cnt_nx == CW'(TAP));
        win_o[g]   <= (cnt_nx != CW'(LAST));
      end
    end
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt < CW'(DIV)); // R2
  AST_HOLD_NO_STEP: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(cnt)); // R2
  AST_START_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(start_o)); // R3
  AST_ONE_WIN_LOW: assert property (@(posedge clk) disable iff (rst)
    $countones(~win_o) <= 1); // R4
endmodule

// File: rtl/tpc_three_phase_gen.sv
module tpc_three_phase_gen #(
  parameter int DIV         = 12,
  parameter int PHASES      = 3,
  parameter int SYNC_STAGES = 2,
  parameter int TIMEOUT     = 64,
  parameter int LOCK_EDGES  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ext_clk,
  input  logic              int_tick,
  output logic [PHASES-1:0] period_start,
  output logic [PHASES-1:0] duty_win,
  output logic              src_int
);
  logic ext_edge, step;

  tpc_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_in(ext_clk), .rise(ext_edge));

  tpc_src_select #(.TIMEOUT(TIMEOUT), .LOCK_EDGES(LOCK_EDGES)) u_sel (
    .clk(clk), .rst(rst), .ext_edge(ext_edge), .int_tick(int_tick),
    .step(step), .use_int(src_int));

  tpc_phase_div #(.DIV(DIV), .PHASES(PHASES)) u_div (
    .clk(clk), .rst(rst), .step(step),
    .start_o(period_start), .win_o(duty_win));

  AST_INT_IGNORES_EXT: assert property (@(posedge clk) disable iff (rst)
    (src_int && !int_tick) |=> (period_start == '0)); // R6
endmodule

// File: tb/tpc_three_phase_gen_test.sv
module tpc_three_phase_gen_test;
  localparam int DIV = 12, PH = 3, TO = 30, LK = 4, WD = 20000;

  logic clk = 0, rst = 1, ext_clk = 0, int_tick = 0;
  logic [PH-1:0] period_start, duty_win;
  logic src_int;

  tpc_three_phase_gen #(.DIV(DIV), .PHASES(PH), .SYNC_STAGES(2),
    .TIMEOUT(TO), .LOCK_EDGES(LK)) uut (
    .clk(clk), .rst(rst), .ext_clk(ext_clk), .int_tick(int_tick),
    .period_start(period_start), .duty_win(duty_win), .src_int(src_int));

  always #5 clk = ~clk;

  int tests = 0, fails = 0, cyc = 0;
  bit checking = 0, done = 0;
  string tag = "R1";

  // behavioural reference
  bit samp[$];
  bit m_int, e, stale, stp, old_int;
  int idle, lock, cnt;
  logic [PH-1:0] exp_ps, exp_win;

  always @(posedge clk) begin
    if (rst) begin
      samp = '{0, 0, 0};
      m_int = 1; idle = 0; lock = 0; cnt = 0;
      for (int i = 0; i < PH; i++) begin
        exp_ps[i]  = 0;
        exp_win[i] = (((i * DIV / PH) + DIV - 1) % DIV) != 0;
      end
    end else begin
      e = samp[1] && !samp[0];
      stale = (idle == TO);
      old_int = m_int;
      stp = old_int ? int_tick : e;
      if (e) idle = 0; else if (!stale) idle++;
      if (!old_int) begin
        if (stale) begin m_int = 0 + 1; lock = 0; end
      end else if (e) begin
        if (lock == LK - 1) begin m_int = 0; lock = 0; end else lock++;
      end else if (stale) lock = 0;
      if (stp) cnt = (cnt + 1) % DIV;
      for (int i = 0; i < PH; i++) begin
        exp_ps[i]  = stp && (cnt == i * DIV / PH);
        exp_win[i] = cnt != (((i * DIV / PH) + DIV - 1) % DIV);
      end
      void'(samp.pop_front());
      samp.push_back(ext_clk);
    end
  end

  task automatic chk(string t, int act, int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h at cycle %0d", t, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (checking) begin
      chk({tag, " period_start"}, period_start, exp_ps);
      chk({tag, " duty_win"}, duty_win, exp_win);
      chk({tag, " src_int"}, src_int, m_int);
    end
  end

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WD && !done) begin
      done = 1;
      fails++; tests++;
      $display("FAIL watchdog: got %0d cycles expected < %0d", cyc, WD);
      summary();
      $finish;
    end
  end

  // hi == 0 holds ext_clk low; tdiv == 0 keeps int_tick low
  task automatic run(int n, int hi, int lo, int tdiv);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (hi == 0) ext_clk = 0;
      else ext_clk = ((k % (hi + lo)) < hi);
      int_tick = (tdiv != 0) && ((k % tdiv) == 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state (exact values)
    chk("R1 src_int", src_int, 1);
    chk("R1 period_start", period_start, 0);
    chk("R1 duty_win", duty_win, 3'b111);
    checking = 1;
    tag = "R2"; run(200, 0, 0, 3);
    tag = "R4"; run(40, 0, 0, 1);
    tag = "R3"; run(80, 0, 0, 5);
    tag = "R6"; run(18, 3, 3, 0);
    tag = "R9"; run(40, 0, 0, 0);
    run(18, 3, 3, 0);
    @(negedge clk);
    chk("R9 src_int still internal", src_int, 1);
    run(40, 0, 0, 0);
    tag = "R8"; run(24, 3, 3, 0);
    run(6, 0, 0, 0);
    chk("R8 src_int returned external", src_int, 0);
    tag = "R5"; run(200, 2, 2, 1);
    tag = "R10"; run(150, 2, 4, 2);
    tag = "R7"; run(40, 0, 0, 0);
    chk("R7 src_int after timeout", src_int, 1);
    run(60, 0, 0, 2);
    checking = 0;
    done = 1;
    summary();
    $finish;
  end
endmodule